// File: doc/BRIEF.md
# Repeat-Mode DMA Channel Address and Count Unit

This block holds the address and transfer-count state of a single DMA channel that runs in repeat mode. Software programs a start address, a 16-bit count word and an 8-bit control byte over a small register bus, then sets the channel enable. Each pulse on the transfer-done strobe counts as one finished transfer. On each such pulse the address moves forward or back by the transfer size and the live counter drops by one.

The count word has two bytes. The high byte holds the programmed transfer number. The low byte is the live counter. When the live counter hits zero with repeat enabled, three things happen on the same clock edge: the counter reloads from the high byte, the address jumps back to the start value captured at the last address write, and the channel stays enabled. The same block of transfers therefore runs again until software clears the enable. With repeat disabled, the terminal transfer clears the enable instead.

The decoded control fields are brought out as separate outputs for the surrounding transfer engine.

Top module: `dma_rpt_chan`

## Requirements
- R1: Register select 0 reads and writes the address. Select 1 reads and writes the count word as {storage byte [15:8], live counter [7:0]}. Select 2 reads and writes the control byte in bits [7:0]. Select 3 reads and writes the channel enable in bit 0. Read data is combinational, and unused upper bits read as zero.
- R2: While the channel is enabled, each transfer-done pulse lowers the live counter by exactly 1 (0x00 wraps to 0xFF), unless that pulse is the terminal one.
- R3: With repeat on, a pulse that takes the live counter from 0x01 to zero loads the storage byte into the live counter on the same edge.
- R4: On that reload the address becomes the captured start address. It is not stepped.
- R5: A reload leaves the enable at 1. The enable drops only when software writes 0 to it.
- R6: A live counter value of 0x00 gives 256 transfers before a reload. A storage byte of 0x00 gives 256 transfers per repeat.
- R7: Each write to the address also captures the written value as the start address used by later restores.
- R8: Reset clears the control byte and the enable to 0. Reset leaves the count word unchanged.
- R9: On a non-terminal transfer the address steps by 1 when control bit 7 is 0 and by 2 when it is 1. It increments when control bit 4 is 0 and decrements when it is 1.
- R10: With repeat off (control bit 5 = 0), the terminal pulse clears the enable, leaves the live counter at 0x00 and steps the address normally.
- R11: A transfer-done pulse while the enable is 0 changes neither the address nor the count word.
- R12: A count-word write in the same cycle as a transfer-done pulse sets the count word to the written value, overriding the decrement. The address still steps.
- R13: The decoded outputs follow the control byte: size is bit 7, ID is bit 6, repeat is bit 5, direction is bit 4 and the factor is bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data for the selected register |
| xfer_done | input | 1 | One finished transfer per high cycle |
| mem_addr | output | ADDR_W | Current memory address |
| chan_en | output | 1 | Channel enable |
| xfer_size | output | 1 | Size field, 1 = word |
| xfer_id | output | 1 | Transfer ID field |
| rpt_en | output | 1 | Repeat enable field |
| xfer_dir | output | 1 | Direction field, 1 = decrement |
| xfer_factor | output | 4 | Transfer factor field |

## Verification
The embedded properties assume that the count word has been written before the first transfer-done pulse arrives with the enable set. This matters because reset does not initialise the count word. The bench always programs the count, control byte and address before it sets the enable. Apart from the single cycle that deliberately tests write priority, it drives register writes and strobes in separate cycles. It sweeps all four size and direction combinations against several counter values, including 0x00 for the 256-transfer case, and runs each sweep through at least two complete repeats.

// File: rtl/dma_rpt_pkg.sv
package dma_rpt_pkg;
    typedef struct packed {
        logic       size;
        logic       tid;
        logic       rpt;
        logic       dir;
        logic [3:0] factor;
    } ctrl_t;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_EN   = 2'd3;
endpackage

// File: rtl/dma_rpt_ctrl_reg.sv
module dma_rpt_ctrl_reg
    import dma_rpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       term_clear,
    output ctrl_t      ctrl_o,
    output logic       en_o
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  en;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl)
            st_d.ctrl = ctrl_t'(wdata);
        if (term_clear)
            st_d.en = 1'b0;
        if (wr_en)
            st_d.en = wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign en_o   = st_q.en;

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q.en && !wr_en && !term_clear) |=> st_q.en) else $error("enable dropped");   // R5
    AST_EN_OFF_TERM: assert property (@(posedge clk) disable iff (rst)
        (term_clear && !wr_en) |=> !st_q.en) else $error("enable kept");                 // R10
endmodule

// File: rtl/dma_rpt_counter.sv
module dma_rpt_counter #(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic               rpt,
    input  logic               wr,
    input  logic [2*CNT_W-1:0] wdata,
    output logic [2*CNT_W-1:0] cnt_o,
    output logic               term_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] store;
        logic [CNT_W-1:0] live;
    } state_t;

    state_t st_d, st_q;
    logic   term;

    assign term = step && (st_q.live == ONE);

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (term && rpt) st_d.live = st_q.store;
            else             st_d.live = st_q.live - ONE;
        end
        if (wr)
            st_d = state_t'(wdata);
    end

    // Count word deliberately has no reset.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o  = st_q;
    assign term_o = term;

    AST_CNT_DEC: assert property (@(posedge clk) disable iff (rst)
        (step && !wr && st_q.live != ONE) |=> st_q.live == $past(st_q.live) - ONE) else $error("bad decrement"); // R2
    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (step && !wr && rpt && st_q.live == ONE) |=> st_q.live == $past(st_q.store)) else $error("bad reload"); // R3
    AST_CNT_WR_WINS: assert property (@(posedge clk) disable iff (rst)
        wr |=> cnt_o == $past(wdata)) else $error("write lost");                                                // R12
endmodule

// File: rtl/dma_rpt_addr.sv
module dma_rpt_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              step,
    input  logic              restore,
    input  logic              size,
    input  logic              dir,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] start;
    } state_t;

    state_t            st_d, st_q;
    logic [ADDR_W-1:0] inc;

    assign inc = size ? ADDR_W'(2) : ADDR_W'(1);

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (restore)  st_d.addr = st_q.start;
            else if (dir) st_d.addr = st_q.addr - inc;
            else          st_d.addr = st_q.addr + inc;
        end
        if (wr) begin
            st_d.addr  = wdata;
            st_d.start = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign addr_o = st_q.addr;

    AST_ADDR_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (step && restore && !wr) |=> st_q.addr == $past(st_q.start)) else $error("restore"); // R4
    AST_ADDR_UP: assert property (@(posedge clk) disable iff (rst)
        (step && !restore && !wr && !dir) |=> st_q.addr == $past(st_q.addr) + $past(inc)) else $error("inc"); // R9
    AST_ADDR_DOWN: assert property (@(posedge clk) disable iff (rst)
        (step && !restore && !wr && dir) |=> st_q.addr == $past(st_q.addr) - $past(inc)) else $error("dec"); // R9
    AST_START_CAPT: assert property (@(posedge clk) disable iff (rst)
        wr |=> st_q.start == $past(wdata)) else $error("capture");                           // R7
endmodule

// File: rtl/dma_rpt_chan.sv
module dma_rpt_chan
    import dma_rpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              chan_en,
    output logic              xfer_size,
    output logic              xfer_id,
    output logic              rpt_en,
    output logic              xfer_dir,
    output logic [3:0]        xfer_factor
);
    localparam int CW_W = 2 * CNT_W;

    ctrl_t           ctrl;
    logic            en;
    logic            step;
    logic            term;
    logic [CW_W-1:0] cnt;
    logic            wr_addr, wr_cnt, wr_ctrl, wr_en;

    assign wr_addr = reg_wr && (reg_sel == SEL_ADDR);
    assign wr_cnt  = reg_wr && (reg_sel == SEL_CNT);
    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_en   = reg_wr && (reg_sel == SEL_EN);
    assign step    = xfer_done && en;

    dma_rpt_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .wr_en      (wr_en),
        .wdata      (reg_wdata[7:0]),
        .term_clear (term && !ctrl.rpt),
        .ctrl_o     (ctrl),
        .en_o       (en)
    );

    dma_rpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .rpt    (ctrl.rpt),
        .wr     (wr_cnt),
        .wdata  (reg_wdata[CW_W-1:0]),
        .cnt_o  (cnt),
        .term_o (term)
    );

    dma_rpt_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_addr),
        .wdata   (reg_wdata),
        .step    (step),
        .restore (term && ctrl.rpt),
        .size    (ctrl.size),
        .dir     (ctrl.dir),
        .addr_o  (mem_addr)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_ADDR: reg_rdata = mem_addr;
            SEL_CNT:  reg_rdata = ADDR_W'(cnt);
            SEL_CTRL: reg_rdata = ADDR_W'(ctrl);
            default:  reg_rdata = ADDR_W'(en);
        endcase
    end

    assign chan_en     = en;
    assign xfer_size   = ctrl.size;
    assign xfer_id     = ctrl.tid;
    assign rpt_en      = ctrl.rpt;
    assign xfer_dir    = ctrl.dir;
    assign xfer_factor = ctrl.factor;

    AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr_addr) |=> $stable(mem_addr)) else $error("idle addr moved"); // R11
    AST_IDLE_CNT: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr_cnt) |=> $stable(cnt)) else $error("idle count moved");      // R11
endmodule

// File: tb/dma_rpt_chan_bench.sv
module dma_rpt_chan_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          xfer_done = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          chan_en, xfer_size, xfer_id, rpt_en, xfer_dir;
    logic [3:0]    xfer_factor;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dma_rpt_chan #(.ADDR_W(AW), .CNT_W(8)) u_dma_rpt_chan (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
        .mem_addr(mem_addr), .chan_en(chan_en), .xfer_size(xfer_size),
        .xfer_id(xfer_id), .rpt_en(rpt_en), .xfer_dir(xfer_dir),
        .xfer_factor(xfer_factor)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [AW-1:0] v);
        reg_sel = sel;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic strobe();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] v;
        logic [AW-1:0] ea;
        logic [7:0]    ec;
        int            nlist [5] = '{1, 2, 3, 7, 0};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(2'd2, v); check("R8 ctrl after reset", v, 0);
        check("R8 enable after reset", chan_en, 0);

        // R8: count survives reset
        wr(2'd1, 16'h1234); wr(2'd2, 16'h00FF); wr(2'd3, 16'h0001);
        @(negedge clk); rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
        rd(2'd1, v); check("R8 count kept", v, 16'h1234);
        rd(2'd2, v); check("R8 ctrl cleared", v, 0);
        check("R8 enable cleared", chan_en, 0);

        // R1 / R13 register access and decode
        wr(2'd2, 16'h00A6);
        rd(2'd2, v); check("R1 ctrl readback", v, 16'h00A6);
        check("R13 size", xfer_size, 1); check("R13 id", xfer_id, 0);
        check("R13 repeat", rpt_en, 1); check("R13 dir", xfer_dir, 0);
        check("R13 factor", xfer_factor, 4'h6);
        wr(2'd2, 16'h0059);
        check("R13 size b", xfer_size, 0); check("R13 id b", xfer_id, 1);
        check("R13 dir b", xfer_dir, 1); check("R13 factor b", xfer_factor, 4'h9);
        wr(2'd0, 16'hBEEF); rd(2'd0, v); check("R1 addr readback", v, 16'hBEEF);

        // R2 R3 R4 R5 R6 R9 sweep
        for (int s = 0; s < 2; s++) begin
            for (int d = 0; d < 2; d++) begin
                foreach (nlist[k]) begin
                    int n = nlist[k];
                    int total = ((n == 0) ? 256 : n) * 2 + 1;
                    wr(2'd3, 16'h0000);
                    wr(2'd2, AW'({s[0], 1'b0, 1'b1, d[0], 4'h3}));
                    wr(2'd0, 16'h8000);
                    wr(2'd1, AW'({n[7:0], n[7:0]}));
                    wr(2'd3, 16'h0001);
                    ea = 16'h8000; ec = n[7:0];
                    for (int t = 0; t < total; t++) begin
                        strobe();
                        if (ec == 8'd1) begin
                            ec = n[7:0]; ea = 16'h8000;          // R3 R4 R6
                        end else begin
                            ec = ec - 8'd1;                       // R2
                            if (d == 0) ea = ea + AW'(s + 1);     // R9
                            else        ea = ea - AW'(s + 1);
                        end
                        check("R4 R9 address", mem_addr, ea);
                        rd(2'd1, v);
                        check("R2 R3 R6 count", v, {n[7:0], ec});
                        check("R5 enable held", chan_en, 1);
                    end
                end
            end
        end

        // R5: software stop
        wr(2'd3, 16'h0000);
        ea = mem_addr;
        strobe();
        check("R5 stopped enable", chan_en, 0);
        check("R5 stopped address", mem_addr, ea);

        // R10 non-repeat terminal, R11 ignore when off
        wr(2'd2, 16'h0000); wr(2'd0, 16'h0100); wr(2'd1, 16'h0502); wr(2'd3, 16'h0001);
        strobe();
        check("R10 addr step", mem_addr, 16'h0101);
        strobe();
        check("R10 addr no restore", mem_addr, 16'h0102);
        rd(2'd1, v); check("R10 counter zero", v, 16'h0500);
        check("R10 enable cleared", chan_en, 0);
        strobe();
        check("R11 addr unchanged", mem_addr, 16'h0102);
        rd(2'd1, v); check("R11 count unchanged", v, 16'h0500);

        // R12 write priority
        wr(2'd2, 16'h0020); wr(2'd1, 16'h0403); wr(2'd3, 16'h0001);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h0909; xfer_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; xfer_done = 1'b0;
        rd(2'd1, v); check("R12 write wins", v, 16'h0909);
        check("R12 addr stepped", mem_addr, 16'h0103);

        // R7 mid-run start capture
        wr(2'd0, 16'h0010); wr(2'd1, 16'h0303);
        strobe(); strobe();
        check("R7 pre addr", mem_addr, 16'h0012);
        wr(2'd0, 16'h0040);
        strobe();
        check("R7 restore to new start", mem_addr, 16'h0040);
        rd(2'd1, v); check("R7 reload", v, 16'h0303);
        rd(2'd3, v); check("R1 enable readback", v, 16'h0001);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule